// File: doc/BRIEF.md
# Paired-Output Clock Divider with Coarse Delay

This block turns a fast distribution clock into a slower clock for a pair of outputs. The divide ratio can be any whole number from 1 to 1045. The output is high for exactly half of every period, for odd ratios as well as even ones. Before the first output edge after a synchronisation event, the block waits for a programmable delay. That delay is counted in whole input cycles and can be refined by one half cycle. Both outputs of the pair carry the same clock.

Software writes a divide value, a whole-cycle delay and a half-step bit through a small write port. These writes go into pending registers. They do nothing to the running clock until the `sync` input is raised. While `sync` is high, the output is held low and the pending values become active. When `sync` drops, the delay count runs, so every divider released by the same `sync` pulse starts in phase.

Divide values of 26 and above select extended mode, which has a longer delay window. Out-of-range settings are clamped, and a flag reports the clamp.

Top module: `cdiv_pair`

## Requirements
- R1: Once running, the output repeats with a period of exactly N input cycles, where N is the active (clamped) divide value, 1 to 1045.
- R2: In each period the output is high for exactly N half input cycles. The high part comes first, for both odd and even N. With N = 1 the output follows the input clock.
- R3: `ext_mode` is 1 when the active divide value is 26 or greater, and 0 otherwise. It changes only while `sync` is high.
- R4: Let E0 be the first rising input edge at which `sync` is sampled low. The first output rising edge comes D half cycles after E0, where D = 2*whole + half.
- R5: In normal mode, D is clamped to 9..24 (4.5 to 12 cycles). When N = 1, D is clamped to 10..24.
- R6: In extended mode, D is clamped to 25..1044 (12.5 to 522 cycles).
- R7: When N = 1 the half-step bit is ignored, so the delay is always a whole number of cycles.
- R8: Writes go to pending registers and do not change the running output. The new divide and delay apply only after the next `sync` pulse.
- R9: From the rising edge that samples `sync` high, both outputs stay low until the new delay has elapsed.
- R10: `clk_out_a` and `clk_out_b` are always equal.
- R11: A pending divide value of 0 is treated as 1, and a value above 1045 is treated as 1045. `cfg_clamped` is 1 from two edges after a write whenever the pending divide or delay had to be clamped, and 0 otherwise.
- R12: The write port has three registers, selected by `cfg_sel`: 0 holds the divide value (bits 10:0), 1 holds the whole-cycle delay (bits 9:0), 2 holds the half-step bit (bit 0), and 3 is ignored.
- R13: After reset, the pending values are divide 2, whole delay 5 and half-step 0. The outputs, `ext_mode` and `cfg_clamped` are 0, and the outputs stay low until the first `sync` pulse, even if writes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Distribution input clock |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Hold-and-realign request, sampled on rising edges |
| cfg_we | input | 1 | Write strobe for the pending registers |
| cfg_sel | input | 2 | Pending register select |
| cfg_wdata | input | 16 | Write data |
| clk_out_a | output | 1 | Divided clock, first output of the pair |
| clk_out_b | output | 1 | Divided clock, second output of the pair |
| ext_mode | output | 1 | Active divide value is in extended mode |
| cfg_clamped | output | 1 | Pending settings were clamped to a legal value |

## Verification
The assertions take for granted two things. First, `sync` is a synchronous level that is high for at least one rising edge. Second, writes change only the pending registers, so the counters move only on their own between `sync` pulses.

The stimulus keeps to this in two ways. It drives `sync`, the write strobe and the data one nanosecond after a rising edge. It holds `sync` for three edges each time. The random configurations cover both modes and include out-of-range divide and delay values, so the clamp paths are exercised along with the legal ones.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  typedef enum logic [1:0] {
    SEL_DIV  = 2'd0,
    SEL_DLY  = 2'd1,
    SEL_HALF = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  localparam int RST_DIV   = 2;
  localparam int RST_WHOLE = 5;

endpackage

// File: rtl/cdiv_cfg.sv
module cdiv_cfg
  import cdiv_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int DIV_MAX   = 1045,
  parameter int EXT_AT    = 26,
  parameter int NRM_MIN_H = 9,
  parameter int NRM_MAX_H = 24,
  parameter int EXT_MIN_H = 25,
  parameter int EXT_MAX_H = 1044,
  parameter int DIV_W     = 11,
  parameter int WH_W      = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DIV_W-1:0]  div_c,
  output logic [WH_W-1:0]   whole_c,
  output logic              half_c,
  output logic              clamped
);

  localparam int RQ_W   = WH_W + 2;
  localparam int ONE_LO = NRM_MIN_H + (NRM_MIN_H % 2);
  localparam int ONE_HI = NRM_MAX_H - (NRM_MAX_H % 2);

  localparam logic [DIV_W-1:0] DMAX_V = DIV_W'(DIV_MAX);
  localparam logic [DIV_W-1:0] EXT_V  = DIV_W'(EXT_AT);
  localparam logic [DIV_W-1:0] ONE_V  = DIV_W'(1);
  localparam logic [RQ_W-1:0]  NLO_V  = RQ_W'(NRM_MIN_H);
  localparam logic [RQ_W-1:0]  NHI_V  = RQ_W'(NRM_MAX_H);
  localparam logic [RQ_W-1:0]  OLO_V  = RQ_W'(ONE_LO);
  localparam logic [RQ_W-1:0]  OHI_V  = RQ_W'(ONE_HI);
  localparam logic [RQ_W-1:0]  ELO_V  = RQ_W'(EXT_MIN_H);
  localparam logic [RQ_W-1:0]  EHI_V  = RQ_W'(EXT_MAX_H);

  logic [DIV_W-1:0] div_r;
  logic [WH_W-1:0]  whole_r;
  logic             half_r;
  logic             is_ext, is_one, hreq;
  logic [RQ_W-1:0]  dreq, lo, hi, dc;

  // Pending registers; the active copy lives in the core.
  always_ff @(posedge clk) begin
    if (rst) begin
      div_r   <= DIV_W'(RST_DIV);
      whole_r <= WH_W'(RST_WHOLE);
      half_r  <= 1'b0;
      clamped <= 1'b0;
    end else begin
      if (we) begin
        case (cfg_sel_e'(sel))
          SEL_DIV:  div_r   <= wdata[DIV_W-1:0];
          SEL_DLY:  whole_r <= wdata[WH_W-1:0];
          SEL_HALF: half_r  <= wdata[0];
          default:  ;
        endcase
      end
      clamped <= (div_c != div_r) || (dc != dreq);
    end
  end

  // Legalise divide first, then delay against the mode window.
  always_comb begin
    if (div_r == '0)          div_c = ONE_V;
    else if (div_r > DMAX_V)  div_c = DMAX_V;
    else                      div_c = div_r;
    is_ext = (div_c >= EXT_V);
    is_one = (div_c == ONE_V);
    hreq   = half_r & ~is_one;
    dreq   = {1'b0, whole_r, hreq};
    lo     = is_ext ? ELO_V : (is_one ? OLO_V : NLO_V);
    hi     = is_ext ? EHI_V : (is_one ? OHI_V : NHI_V);
    if (dreq < lo)       dc = lo;
    else if (dreq > hi)  dc = hi;
    else                 dc = dreq;
    whole_c = WH_W'(dc >> 1);
    half_c  = dc[0];
  end

  a_r11_flag_high: assert property (@(posedge clk) disable iff (rst)
    (div_r > DMAX_V) |=> clamped);
  a_r5_normal_window: assert property (@(posedge clk) disable iff (rst)
    (!is_ext) |-> ({1'b0, whole_c, half_c} >= NLO_V && {1'b0, whole_c, half_c} <= NHI_V));
  a_r6_ext_window: assert property (@(posedge clk) disable iff (rst)
    is_ext |-> ({1'b0, whole_c, half_c} >= ELO_V && {1'b0, whole_c, half_c} <= EHI_V));
  a_r7_one_no_half: assert property (@(posedge clk) disable iff (rst)
    (div_c == ONE_V) |-> !half_c);

endmodule

// File: rtl/cdiv_core.sv
module cdiv_core #(
  parameter int EXT_AT = 26,
  parameter int DIV_W  = 11,
  parameter int WH_W   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync,
  input  logic [DIV_W-1:0] div_c,
  input  logic [WH_W-1:0]  whole_c,
  input  logic             half_c,
  output logic             run,
  output logic             p,
  output logic             one_sel,
  output logic             odd_sel,
  output logic             half_sel,
  output logic             ext_mode
);

  localparam logic [DIV_W-1:0] EXT_V = DIV_W'(EXT_AT);
  localparam logic [DIV_W-1:0] ONE_V = DIV_W'(1);

  logic [DIV_W-1:0] act_div, cnt, cnt_n, hcnt;
  logic [WH_W-1:0]  dcnt;
  logic             act_half, armed;

  always_comb begin
    hcnt  = act_div >> 1;
    cnt_n = (cnt == act_div - ONE_V) ? '0 : cnt + ONE_V;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_div  <= '0;
      act_half <= 1'b0;
      ext_mode <= 1'b0;
      dcnt     <= '0;
      cnt      <= '0;
      armed    <= 1'b0;
      run      <= 1'b0;
      p        <= 1'b0;
    end else if (sync) begin
      act_div  <= div_c;
      act_half <= half_c;
      ext_mode <= (div_c >= EXT_V);
      dcnt     <= whole_c;
      cnt      <= '0;
      armed    <= 1'b1;
      run      <= 1'b0;
      p        <= 1'b0;
    end else if (armed && !run) begin
      if (dcnt == '0) begin
        run <= 1'b1;
        p   <= 1'b1;
        cnt <= '0;
      end else begin
        dcnt <= dcnt - 1'b1;
      end
    end else if (run) begin
      cnt <= cnt_n;
      p   <= (cnt_n < hcnt);
    end
  end

  assign one_sel  = (act_div == ONE_V);
  assign odd_sel  = act_div[0];
  assign half_sel = act_half;

  a_r9_sync_stops_run: assert property (@(posedge clk) disable iff (rst)
    sync |=> !run);
  a_r1_cnt_in_period: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < act_div));
  a_r4_start_after_count: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> ($past(dcnt) == '0 && !$past(sync)));
  a_r3_mode_matches_div: assert property (@(posedge clk) disable iff (rst)
    ext_mode == (act_div >= EXT_V));
  a_r3_mode_only_on_sync: assert property (@(posedge clk) disable iff (rst)
    !$past(sync) |-> $stable(ext_mode));

endmodule

// File: rtl/cdiv_phase.sv
module cdiv_phase (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic p,
  input  logic one_sel,
  input  logic odd_sel,
  input  logic half_sel,
  output logic clk_out
);

  logic n_q, p2_q, pick;

  // Falling-edge retime of the count: odd duty and half-step share it.
  always_ff @(negedge clk) begin
    if (rst) n_q <= 1'b0;
    else     n_q <= p;
  end

  always_ff @(posedge clk) begin
    if (rst) p2_q <= 1'b0;
    else     p2_q <= p;
  end

  always_comb begin
    if (one_sel) begin
      pick = clk;
    end else begin
      case ({half_sel, odd_sel})
        2'b00:   pick = p;
        2'b01:   pick = p | n_q;
        2'b10:   pick = n_q;
        default: pick = n_q | p2_q;
      endcase
    end
    clk_out = run & pick;
  end

  a_r2_idle_shadow_low: assert property (@(posedge clk) disable iff (rst)
    !run |=> !p2_q);

endmodule

// File: rtl/cdiv_pair.sv
module cdiv_pair #(
  parameter int DATA_W    = 16,
  parameter int DIV_MAX   = 1045,
  parameter int EXT_AT    = 26,
  parameter int NRM_MIN_H = 9,
  parameter int NRM_MAX_H = 24,
  parameter int EXT_MIN_H = 25,
  parameter int EXT_MAX_H = 1044
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              clk_out_a,
  output logic              clk_out_b,
  output logic              ext_mode,
  output logic              cfg_clamped
);

  localparam int DIV_W = $clog2(DIV_MAX + 1);
  localparam int WH_W  = $clog2(EXT_MAX_H + 1) - 1;

  logic [DIV_W-1:0] div_c;
  logic [WH_W-1:0]  whole_c;
  logic             half_c, run, p, one_sel, odd_sel, half_sel, clk_div;

  cdiv_cfg #(
    .DATA_W(DATA_W), .DIV_MAX(DIV_MAX), .EXT_AT(EXT_AT),
    .NRM_MIN_H(NRM_MIN_H), .NRM_MAX_H(NRM_MAX_H),
    .EXT_MIN_H(EXT_MIN_H), .EXT_MAX_H(EXT_MAX_H),
    .DIV_W(DIV_W), .WH_W(WH_W)
  ) cfg_i (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .div_c(div_c), .whole_c(whole_c), .half_c(half_c), .clamped(cfg_clamped)
  );

  cdiv_core #(
    .EXT_AT(EXT_AT), .DIV_W(DIV_W), .WH_W(WH_W)
  ) core_i (
    .clk(clk), .rst(rst), .sync(sync),
    .div_c(div_c), .whole_c(whole_c), .half_c(half_c),
    .run(run), .p(p), .one_sel(one_sel), .odd_sel(odd_sel),
    .half_sel(half_sel), .ext_mode(ext_mode)
  );

  cdiv_phase phase_i (
    .clk(clk), .rst(rst), .run(run), .p(p),
    .one_sel(one_sel), .odd_sel(odd_sel), .half_sel(half_sel),
    .clk_out(clk_div)
  );

  assign clk_out_a = clk_div;
  assign clk_out_b = clk_div;

endmodule

// File: tb/cdiv_pair_tb_top.sv
module cdiv_pair_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        clk_out_a, clk_out_b, ext_mode, cfg_clamped;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cdiv_pair dut_i (
    .clk(clk), .rst(rst), .sync(sync), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .clk_out_a(clk_out_a), .clk_out_b(clk_out_b),
    .ext_mode(ext_mode), .cfg_clamped(cfg_clamped)
  );

  function automatic int fix_div(input int d);
    if (d < 1) return 1;
    if (d > 1045) return 1045;
    return d;
  endfunction

  function automatic int req_d(input int n, input int w, input int h);
    return 2 * w + ((n != 1) ? h : 0);
  endfunction

  function automatic int fix_d(input int n, input int w, input int h);
    int r, lo, hi;
    r  = req_d(n, w, h);
    lo = (n >= 26) ? 25 : ((n == 1) ? 10 : 9);
    hi = (n >= 26) ? 1044 : 24;
    if (r < lo) return lo;
    if (r > hi) return hi;
    return r;
  endfunction

  function automatic int exp_out(input int k, input int n, input int d);
    if (k < d) return 0;
    return (((k - d) % (2 * n)) < n) ? 1 : 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int s, input int d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = 2'(s); cfg_wdata = 16'(d);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic do_sync();
    @(posedge clk); #1 sync = 1'b1;
    repeat (3) @(posedge clk);
    #1 sync = 1'b0;
  endtask

  // Samples one value per half cycle starting just after E0.
  task automatic run_trace(input int n, input int d, input int kmax, input string req);
    int bad_k, bad_a, bad_e;
    bit pair_bad;
    bad_k = -1; bad_a = 0; bad_e = 0; pair_bad = 0;
    @(posedge clk); #2;
    for (int k = 0; k < kmax; k++) begin
      int e;
      e = exp_out(k, n, d);
      if (bad_k < 0 && int'(clk_out_a) != e) begin
        bad_k = k; bad_a = int'(clk_out_a); bad_e = e;
      end
      if (clk_out_a !== clk_out_b) pair_bad = 1;
      #4;
    end
    if (bad_k >= 0) $display("  trace N=%0d D=%0d first mismatch at half %0d", n, d, bad_k);
    check(bad_k < 0, req, bad_a, bad_e);
    check(!pair_bad, "R10 pair equal", int'(pair_bad), 0);
  endtask

  task automatic test_cfg(input int dv, input int w, input int h, input string req);
    int n, d, fl;
    n  = fix_div(dv);
    d  = fix_d(n, w, h);
    fl = ((n != dv) || (d != req_d(n, w, h))) ? 1 : 0;
    wr(0, dv); wr(1, w); wr(2, h);
    repeat (2) @(posedge clk);
    #2 check(int'(cfg_clamped) == fl, "R11 clamp flag", int'(cfg_clamped), fl);
    do_sync();
    run_trace(n, d, d + 4 * n + 4, req);
    check(int'(ext_mode) == ((n >= 26) ? 1 : 0), "R3 ext_mode", int'(ext_mode), (n >= 26) ? 1 : 0);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h1f3a);
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R13: reset state, no output before the first sync even with a write
    #1 check(clk_out_a == 1'b0 && clk_out_b == 1'b0, "R13 reset out", int'(clk_out_a), 0);
    check(ext_mode == 1'b0, "R13 reset ext", int'(ext_mode), 0);
    check(cfg_clamped == 1'b0, "R13 reset flag", int'(cfg_clamped), 0);
    begin
      bit seen;
      seen = 0;
      wr(0, 3);
      for (int i = 0; i < 80; i++) begin
        #4;
        if (clk_out_a !== 1'b0) seen = 1;
      end
      check(!seen, "R13 idle before sync", int'(seen), 0);
    end
    // R13: reset default pending values (div 2, D 10)
    wr(0, 2);
    do_sync();
    run_trace(2, 10, 40, "R13 defaults R4");

    // Directed corners
    test_cfg(1, 6, 1, "R7 div1 half ignored R2");
    test_cfg(1, 4, 0, "R5 div1 low clamp");
    test_cfg(2, 4, 1, "R5 min 4.5 R4");
    test_cfg(3, 7, 1, "R2 odd half");
    test_cfg(25, 20, 0, "R5 upper clamp normal");
    test_cfg(26, 3, 0, "R6 ext lower clamp R3");
    test_cfg(1045, 1023, 1, "R6 ext upper clamp R1");
    test_cfg(0, 5, 0, "R11 div zero R1");
    test_cfg(2000, 300, 1, "R11 div high R1");
    test_cfg(7, 8, 1, "R1 odd normal");

    // R12: select 3 is ignored
    wr(0, 4); wr(1, 6); wr(2, 0);
    wr(3, 16'hffff);
    do_sync();
    run_trace(4, 12, 60, "R12 sel3 ignored");

    // R8: writes without sync leave the running clock alone
    do_sync();
    fork
      run_trace(4, 12, 160, "R8 pending hold");
      begin
        repeat (12) @(posedge clk);
        wr(0, 7); wr(1, 9); wr(2, 1);
      end
    join
    do_sync();
    run_trace(7, 19, 19 + 28 + 4, "R8 apply after sync");

    // R9: sync forces both outputs low, then realigns
    repeat (5) @(posedge clk);
    #1 sync = 1'b1;
    begin
      bit hi_seen;
      hi_seen = 0;
      for (int i = 0; i < 4; i++) begin
        @(posedge clk); #2;
        if (clk_out_a !== 1'b0 || clk_out_b !== 1'b0) hi_seen = 1;
        #4;
        if (clk_out_a !== 1'b0 || clk_out_b !== 1'b0) hi_seen = 1;
      end
      check(!hi_seen, "R9 held low", int'(hi_seen), 0);
    end
    @(posedge clk); #1 sync = 1'b0;
    run_trace(7, 19, 60, "R9 realign");

    // Random configurations, both modes
    for (int it = 0; it < 24; it++) begin
      int dv, w, h;
      if ((it % 4) == 3) begin
        dv = $urandom_range(20, 1100);
        w  = $urandom_range(0, 600);
      end else begin
        dv = $urandom_range(0, 40);
        w  = $urandom_range(0, 30);
      end
      h = $urandom_range(0, 1);
      test_cfg(dv, w, h, "R1 R2 R4 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule